// File: doc/BRIEF.md
# Decoded Johnson Slot Counter

This block is a synchronous twisted-ring counter with a configurable number of flip-flop stages. A ring of `STAGES` bits moves through `2*STAGES` distinct patterns. Each pattern is decoded into its own one-hot time-slot output, and each of those outputs looks at only two ring bits. Five stages give a divide-by-ten sequencer with ten slots. Four stages give a divide-by-eight sequencer with eight slots.

Counting is gated by an active-high inhibit input. An active-high asynchronous reset returns the ring to its zero count. The carry output is a square wave with a period of `2*STAGES` clocks. Its rising edge marks the wrap from the last slot back to slot 0, so it can clock the next counter in a ripple chain.

A legality check watches the ring. When the ring holds a pattern that is not one of the `2*STAGES` legal patterns, the next enabled edge loads the zero count. The counter therefore cannot lock up in a parasitic cycle.

Top module: `johnson_slot_counter`

## Requirements
- R1: With `STAGES` = S the block has N = 2*S slot outputs. Slot k is bit k of `slot_o`. The slots follow the order 0, 1, ..., N-1 and then wrap to 0, for both S = 5 (N = 10) and S = 4 (N = 8).
- R2: On each rising clock edge with `inhibit` low and `rst` low, the active slot advances by exactly one position.
- R3: While `inhibit` is high, clock edges leave `slot_o` and `carry_o` unchanged.
- R4: A high `rst` forces `slot_o` to the value 1 (slot 0 high) and drives `carry_o` high. This happens at once, without waiting for a clock edge, and it overrides both `inhibit` and the clock.
- R5: In every legal state exactly one bit of `slot_o` is high. Each slot stays high for one full clock period per enabled edge.
- R6: `carry_o` is high while slots 0 to S-1 are active and low while slots S to N-1 are active. It rises only on the wrap from slot N-1 to slot 0.
- R7: Suppose the ring holds any of the 2^S - N illegal patterns at an enabled clock edge. That edge then loads the zero count, so slot 0 is high and `carry_o` is high.
- R8: After `rst` is released, the first enabled edge moves the counter to slot 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset to the zero count |
| inhibit | input | 1 | High blocks counting on clock edges |
| slot_o | output | 2*STAGES | One-hot decoded time slots |
| carry_o | output | 1 | Square carry, high during the first half of the count |

## Verification
The hardest behaviour to reach is recovery from an illegal ring pattern. Reset and counting only ever produce legal patterns, so no sequence on the ports can create one. The bench reaches these states by briefly forcing each illegal pattern onto the ring register between clock edges, with `inhibit` low. It then releases the force and expects slot 0 after the next edge. It does this for every illegal pattern of both the five-stage and the four-stage instance. Reset asserted mid-cycle while `inhibit` is high is also exercised, to show that reset overrides inhibit and acts without a clock edge.

// File: rtl/jc_pkg.sv
`timescale 1ns/1ps
package jc_pkg;

  localparam int RING_MAX = 16;
  typedef logic [RING_MAX-1:0] ring_vec_t;

  // Legal twisted-ring patterns have at most one boundary between
  // adjacent bits (ones packed low, or zeros packed low).
  function automatic logic ring_is_legal(ring_vec_t r, int st);
    int flips;
    flips = 0;
    for (int i = 0; i < RING_MAX - 1; i++) begin
      if ((i + 1 < st) && (r[i] != r[i+1])) flips++;
    end
    return (flips <= 1);
  endfunction

  // One twisted-ring step: shift toward the top, inverted top bit enters at 0.
  function automatic ring_vec_t ring_advance(ring_vec_t r, int st);
    ring_vec_t n;
    n = '0;
    n[0] = ~r[st-1];
    for (int i = 1; i < RING_MAX; i++) begin
      if (i < st) n[i] = r[i-1];
    end
    return n;
  endfunction

  // Carry level for a given count: high in the first half of the cycle.
  function automatic logic carry_for_count(int count, int st);
    return (count < st);
  endfunction

endpackage

// File: rtl/jc_ring_state.sv
`timescale 1ns/1ps
module jc_ring_state #(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [STAGES-1:0] ring_q,
  output logic              legal_o
);
  import jc_pkg::*;

  ring_vec_t             wide_cur;
  ring_vec_t             wide_nxt;
  logic [STAGES-1:0]     ring_nxt;

  always_comb begin
    wide_cur = '0;
    wide_cur[STAGES-1:0] = ring_q;
    legal_o  = ring_is_legal(wide_cur, STAGES);
    wide_nxt = ring_advance(wide_cur, STAGES);
    // Anti-lock: a non-legal pattern is replaced by the zero count.
    ring_nxt = legal_o ? wide_nxt[STAGES-1:0] : '0;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          ring_q <= '0;
    else if (advance) ring_q <= ring_nxt;
  end

endmodule

// File: rtl/jc_slot_decode.sv
`timescale 1ns/1ps
module jc_slot_decode #(
  parameter int STAGES = 5,
  localparam int SLOTS = 2 * STAGES
) (
  input  logic [STAGES-1:0] ring,
  output logic [SLOTS-1:0]  slot_o
);

  // Every slot is a two-input AND of ring bits.
  assign slot_o[0]      = ~ring[0] & ~ring[STAGES-1];
  assign slot_o[STAGES] =  ring[0] &  ring[STAGES-1];

  for (genvar k = 1; k < STAGES; k++) begin : g_edge
    assign slot_o[k]          =  ring[k-1] & ~ring[k];
    assign slot_o[STAGES + k] = ~ring[k-1] &  ring[k];
  end

endmodule

// File: rtl/jc_carry_tap.sv
`timescale 1ns/1ps
module jc_carry_tap #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0] ring,
  output logic              carry_o
);
  // Top ring bit is low exactly through the first half of the count.
  assign carry_o = ~ring[STAGES-1];
endmodule

// File: rtl/johnson_slot_counter.sv
`timescale 1ns/1ps
module johnson_slot_counter #(
  parameter int STAGES = 5,
  localparam int SLOTS = 2 * STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inhibit,
  output logic [SLOTS-1:0] slot_o,
  output logic             carry_o
);

  logic [STAGES-1:0] ring_q;
  logic              ring_legal;
  logic              advance;
  logic              wrap_event;

  assign advance    = ~inhibit;
  assign wrap_event = advance & slot_o[SLOTS-1];

  jc_ring_state #(.STAGES(STAGES)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .ring_q  (ring_q),
    .legal_o (ring_legal)
  );

  jc_slot_decode #(.STAGES(STAGES)) u_decode (
    .ring   (ring_q),
    .slot_o (slot_o)
  );

  jc_carry_tap #(.STAGES(STAGES)) u_carry (
    .ring    (ring_q),
    .carry_o (carry_o)
  );

  assert_reset_R4: assert property (@(posedge clk)
    rst |-> (slot_o == SLOTS'(1)) && carry_o);

  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (!inhibit && ring_legal) |=>
      (!ring_legal || slot_o == {$past(slot_o[SLOTS-2:0]), $past(slot_o[SLOTS-1])}));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (inhibit && ring_legal) |=> (!ring_legal || ($stable(slot_o) && $stable(carry_o))));

  assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    ring_legal |-> ($countones(slot_o) == 1));

  assert_carry_level_R6: assert property (@(posedge clk) disable iff (rst)
    ring_legal |-> (carry_o == (|slot_o[STAGES-1:0])));

  assert_carry_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (wrap_event && ring_legal) |=> $rose(carry_o));

  assert_recover_R7: assert property (@(posedge clk) disable iff (rst)
    (!inhibit && !ring_legal) |=> (slot_o == SLOTS'(1)));

endmodule

// File: tb/johnson_slot_counter_bench.sv
`timescale 1ns/100ps
module johnson_slot_counter_bench;

  localparam int S5 = 5;
  localparam int N5 = 10;
  localparam int S4 = 4;
  localparam int N4 = 8;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic inhibit = 1'b0;
  logic [N5-1:0] slot5;
  logic [N4-1:0] slot4;
  logic carry5;
  logic carry4;
  logic [S5-1:0] pat5;
  logic [S4-1:0] pat4;

  always #2 clk = ~clk;

  johnson_slot_counter #(.STAGES(S5)) u_johnson_slot_counter (
    .clk(clk), .rst(rst), .inhibit(inhibit), .slot_o(slot5), .carry_o(carry5));

  johnson_slot_counter #(.STAGES(S4)) u_johnson_slot_counter_oct (
    .clk(clk), .rst(rst), .inhibit(inhibit), .slot_o(slot4), .carry_o(carry4));

  typedef struct { int c5; int c4; string req; } exp_t;
  exp_t sb[$];
  int m5 = 0;
  int m4 = 0;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Ring pattern a legal count maps to, restated from the slot order.
  function automatic int pattern_of(int c, int s);
    int full;
    full = (1 << s) - 1;
    if (c <= s) return (1 << c) - 1;
    return full & ~((1 << (c - s)) - 1);
  endfunction

  function automatic bit is_legal_pat(int p, int s);
    for (int c = 0; c < 2 * s; c++) if (pattern_of(c, s) == p) return 1'b1;
    return 1'b0;
  endfunction

  // Monitor: compare after each edge against the scoreboard head.
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      check(slot5 == N5'(1 << e.c5), e.req, "slot5", 32'(slot5), 32'(1 << e.c5));
      check(slot4 == N4'(1 << e.c4), e.req, "slot4", 32'(slot4), 32'(1 << e.c4));
      check(carry5 == (e.c5 < S5), "R6", "carry5", 32'(carry5), 32'(e.c5 < S5));
      check(carry4 == (e.c4 < S4), "R6", "carry4", 32'(carry4), 32'(e.c4 < S4));
      check($countones(slot5) == 1, "R5", "onehot5", 32'($countones(slot5)), 32'd1);
    end
  end

  task automatic push(string req);
    exp_t e;
    e.c5 = m5; e.c4 = m4; e.req = req;
    sb.push_back(e);
  endtask

  task automatic step(bit inh, string req);
    @(negedge clk);
    inhibit = inh;
    if (!inh) begin
      m5 = (m5 + 1) % N5;
      m4 = (m4 + 1) % N4;
    end
    push(req);
  endtask

  task automatic do_reset(bit inh);
    @(negedge clk);
    inhibit = inh;
    #0.5 rst = 1'b1;
    #0.5;
    check(slot5 == N5'(1), "R4", "async slot5", 32'(slot5), 32'd1);
    check(slot4 == N4'(1), "R4", "async slot4", 32'(slot4), 32'd1);
    check(carry5 && carry4, "R4", "async carry", 32'({carry5, carry4}), 32'd3);
    m5 = 0; m4 = 0;
    push("R4");
    @(negedge clk);
    rst = 1'b0;
    inhibit = 1'b0;
    m5 = 1; m4 = 1;
    push("R8");
  endtask

  initial begin
    #1 rst = 1'b1;
    #0.5;
    check(slot5 == N5'(1) && carry5, "R4", "initial reset", 32'(slot5), 32'd1);
    @(negedge clk);
    rst = 1'b0;
    inhibit = 1'b0;
    m5 = 1; m4 = 1;
    push("R8");

    // Full wraps of both sizes (R1, R2, carry R6)
    for (int i = 0; i < 25; i++) step(1'b0, "R1/R2");

    // Inhibit interleaving (R3)
    for (int i = 0; i < 20; i++) step(i[0] | i[2], "R3");
    for (int i = 0; i < 4; i++) step(1'b1, "R3");

    // Reset with inhibit high and mid-count
    do_reset(1'b1);
    for (int i = 0; i < 7; i++) step(1'b0, "R2");
    do_reset(1'b0);

    // Illegal ring patterns of the five-stage instance (R7)
    for (int p = 0; p < (1 << S5); p++) begin
      if (!is_legal_pat(p, S5)) begin
        @(negedge clk);
        inhibit = 1'b0;
        pat5 = S5'(p);
        force u_johnson_slot_counter.u_ring.ring_q = pat5;
        #0.5;
        release u_johnson_slot_counter.u_ring.ring_q;
        m5 = 0;
        m4 = (m4 + 1) % N4;
        push("R7");
        step(1'b0, "R7");
      end
    end

    // Illegal ring patterns of the four-stage instance (R7)
    for (int p = 0; p < (1 << S4); p++) begin
      if (!is_legal_pat(p, S4)) begin
        @(negedge clk);
        inhibit = 1'b0;
        pat4 = S4'(p);
        force u_johnson_slot_counter_oct.u_ring.ring_q = pat4;
        #0.5;
        release u_johnson_slot_counter_oct.u_ring.ring_q;
        m4 = 0;
        m5 = (m5 + 1) % N5;
        push("R7");
        step(1'b0, "R7");
      end
    end

    for (int i = 0; i < 12; i++) step(1'b0, "R1");

    wait (sb.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule